// File: doc/BRIEF.md
# Panel Colour Depth Reducer with Spatial Dither and Temporal Modulation

This block sits in a display pipeline in front of a low-depth TFT panel. Each clock it takes one pixel of six bits per colour channel, together with the parity of its column and row, the data-enable and sync flags, and a pulse that marks the start of a frame. It produces the same pixel cut down to three bits per channel for a 9-bit panel or to four bits per channel for a 12-bit panel, depending on a width-select input.

Plain truncation would throw away the low bits. This block instead rounds each channel up by one code when the discarded fraction, plus a position- and frame-dependent threshold, overflows. A 2x2 ordered pattern spreads the rounding over neighbouring pixels. A two-phase temporal scheme alternates a shade between two adjacent codes on successive frames, with neighbouring pixels in opposite phase. Each technique has its own enable. When both are on, the panel shows many more apparent colours than its native count.

The result is registered once, and the enable and sync flags are delayed by the same single register so they stay aligned with the pixel.

Top module: `pdf_dither_frm`

## Requirements
- R1: `out_de`, `out_hs` and `out_vs` equal `in_de`, `in_hs` and `in_vs` from one clock earlier.
- R2: While `rst_n` is low at a clock edge, every output becomes 0 and the frame parity becomes 0.
- R3: With `cfg_dither_en`=0 and `cfg_frm_en`=0, each output channel equals the input channel shifted right by 2 (`cfg_wide`=1) or by 3 (`cfg_wide`=0).
- R4: With dither only, the pattern rank is taken from {row bit, column bit}: 00 gives 0, 01 gives 2, 10 gives 3, 11 gives 1. With D discarded bits, the threshold is rank*2^(D-1). The channel rounds up by one code when 2*low + threshold >= 2^(D+1), where low is the discarded field.
- R5: With temporal modulation only, the phase is frame parity XOR column bit XOR row bit, and the threshold is phase*2^D. The same round-up rule as R4 applies, so a channel steps up on phase-1 pixels exactly when its discarded field is at least half a code.
- R6: With both enabled, the threshold is rank*2^(D-1) + phase, with the same round-up rule.
- R7: Round-up saturates: an input of all ones gives 15 in 12-bit mode and 7 in 9-bit mode, never wrapping.
- R8: The frame parity toggles on every clock edge where `frame_start` is 1. A pixel presented in that same cycle still uses the value from before the toggle.
- R9: In 9-bit mode, bit 3 of every output channel is 0.
- R10: When `out_de` is 0, all output channels are 0.
- R11: While enabled, every output channel is either its truncated value or one code above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_dither_en | input | 1 | Enable 2x2 spatial pattern |
| cfg_frm_en | input | 1 | Enable two-frame temporal modulation |
| cfg_wide | input | 1 | 1: 4 bits per channel, 0: 3 bits per channel |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| in_de | input | 1 | Input pixel valid |
| in_hs | input | 1 | Input horizontal sync |
| in_vs | input | 1 | Input vertical sync |
| in_x_odd | input | 1 | Least significant bit of the pixel column |
| in_y_odd | input | 1 | Least significant bit of the pixel row |
| in_r | input | 6 | Red input |
| in_g | input | 6 | Green input |
| in_b | input | 6 | Blue input |
| out_de | output | 1 | Delayed pixel valid |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |
| out_r | output | 4 | Red output |
| out_g | output | 4 | Green output |
| out_b | output | 4 | Blue output |

## Verification
The hardest case to reach is the interplay of frame parity with pixel position. Temporal rounding only shows when a half-code input meets a phase-1 pixel, and the phase flips with every frame pulse. The stimulus therefore sweeps all 64 input codes over all four position parities in both widths and under every enable combination, with frame pulses at irregular intervals. It also places frame pulses on active pixels, to show that the pixel in the pulse cycle still uses the pre-toggle parity. A behavioural model tracks the parity independently and predicts every output on every clock.

// File: rtl/pdf_pkg.sv
// Shared types and helpers for the panel depth reducer.
// Assumes a 2x2 ordered pattern indexed by {row bit, column bit}.
package pdf_pkg;

    // Timing flags that travel alongside a pixel.
    typedef struct packed {
        logic de;
        logic hs;
        logic vs;
    } pdf_sync_t;

    // Rank of a position inside the 2x2 ordered pattern.
    function automatic logic [1:0] pdf_rank(input logic y_odd, input logic x_odd);
        logic [1:0] r;
        case ({y_odd, x_odd})
            2'b00:   r = 2'd0;
            2'b01:   r = 2'd2;
            2'b10:   r = 2'd3;
            default: r = 2'd1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pdf_phase.sv
// Frame parity tracker and per-pixel pattern/phase decode.
// Assumes frame_start is a single-cycle pulse; the pixel presented in
// the pulse cycle uses the parity from before the toggle.
module pdf_phase (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic       x_odd,
    input  logic       y_odd,
    output logic [1:0] rank,
    output logic       phase,
    output logic       parity
);
    import pdf_pkg::*;

    // Toggle the frame parity on every frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)           parity <= 1'b0;
        else if (frame_start) parity <= ~parity;
    end

    // Decode pattern rank and checkerboard temporal phase.
    always_comb begin
        rank  = pdf_rank(y_odd, x_odd);
        phase = parity ^ x_odd ^ y_odd;
    end
endmodule

// File: rtl/pdf_round.sv
// Reduces one channel by a fixed number of discarded bits D, adding a
// threshold held in D+1 fractional bits and saturating at full scale.
// Assumes D >= 2 so the pattern rank and phase bit never overlap.
module pdf_round #(
    parameter int IN_W  = 6,
    parameter int DROP  = 2,
    localparam int OW   = IN_W - DROP,
    localparam int TW   = DROP + 1
) (
    input  logic [IN_W-1:0] pix,
    input  logic            dith_en,
    input  logic            frm_en,
    input  logic [1:0]      rank,
    input  logic            phase,
    output logic [OW-1:0]   q
);
    logic [OW-1:0]  upper;
    logic [DROP-1:0] low;
    logic [TW-1:0]  thr;
    logic [TW:0]    sum;
    logic           carry;

    // Split the pixel into kept and discarded fields.
    always_comb begin
        upper = pix[IN_W-1:DROP];
        low   = pix[DROP-1:0];
    end

    // Select the threshold according to which techniques are on.
    always_comb begin
        case ({dith_en, frm_en})
            2'b10:   thr = {rank, {(DROP-1){1'b0}}};
            2'b01:   thr = {phase, {DROP{1'b0}}};
            2'b11:   thr = {rank, {(DROP-1){1'b0}}} | {{(TW-1){1'b0}}, phase};
            default: thr = '0;
        endcase
    end

    // Add the threshold to the doubled fraction and detect overflow.
    always_comb begin
        sum   = {1'b0, low, 1'b0} + {1'b0, thr};
        carry = sum[TW];
    end

    // Round up one code unless already at full scale.
    always_comb begin
        if (carry && (upper != {OW{1'b1}})) q = upper + 1'b1;
        else                                q = upper;
    end
endmodule

// File: rtl/pdf_chan.sv
// One colour channel: both panel widths are built, the width select
// picks one; narrow results are zero-extended to the wide width.
// Assumes NARROW_W < WIDE_W < IN_W - 1.
module pdf_chan #(
    parameter int IN_W     = 6,
    parameter int WIDE_W   = 4,
    parameter int NARROW_W = 3,
    localparam int PAD_W   = WIDE_W - NARROW_W
) (
    input  logic [IN_W-1:0]   pix,
    input  logic              wide,
    input  logic              dith_en,
    input  logic              frm_en,
    input  logic [1:0]        rank,
    input  logic              phase,
    output logic [WIDE_W-1:0] q
);
    logic [WIDE_W-1:0]   q_wide;
    logic [NARROW_W-1:0] q_narrow;

    pdf_round #(.IN_W(IN_W), .DROP(IN_W - WIDE_W)) u_wide (
        .pix(pix), .dith_en(dith_en), .frm_en(frm_en),
        .rank(rank), .phase(phase), .q(q_wide)
    );

    pdf_round #(.IN_W(IN_W), .DROP(IN_W - NARROW_W)) u_narrow (
        .pix(pix), .dith_en(dith_en), .frm_en(frm_en),
        .rank(rank), .phase(phase), .q(q_narrow)
    );

    // Choose the result for the selected panel width.
    always_comb begin
        q = wide ? q_wide : {{PAD_W{1'b0}}, q_narrow};
    end
endmodule

// File: rtl/pdf_dither_frm.sv
// Top of the panel depth reducer: three channel rounders share one
// pattern/phase decode; result and timing flags are registered once.
// Assumes configuration inputs are quasi-static within a frame.
module pdf_dither_frm #(
    parameter int IN_W     = 6,
    parameter int WIDE_W   = 4,
    parameter int NARROW_W = 3,
    localparam int NCH     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_dither_en,
    input  logic              cfg_frm_en,
    input  logic              cfg_wide,
    input  logic              frame_start,
    input  logic              in_de,
    input  logic              in_hs,
    input  logic              in_vs,
    input  logic              in_x_odd,
    input  logic              in_y_odd,
    input  logic [IN_W-1:0]   in_r,
    input  logic [IN_W-1:0]   in_g,
    input  logic [IN_W-1:0]   in_b,
    output logic              out_de,
    output logic              out_hs,
    output logic              out_vs,
    output logic [WIDE_W-1:0] out_r,
    output logic [WIDE_W-1:0] out_g,
    output logic [WIDE_W-1:0] out_b
);
    import pdf_pkg::*;

    logic [1:0]        rank;
    logic              phase;
    logic              frame_par;
    logic [IN_W-1:0]   pix [NCH];
    logic [WIDE_W-1:0] rnd [NCH];
    logic [WIDE_W-1:0] q_reg [NCH];
    pdf_sync_t         sync_reg;

    pdf_phase u_phase (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .x_odd(in_x_odd), .y_odd(in_y_odd),
        .rank(rank), .phase(phase), .parity(frame_par)
    );

    // Gather the channels into an array for the generate loop.
    always_comb begin
        pix[0] = in_r;
        pix[1] = in_g;
        pix[2] = in_b;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        pdf_chan #(.IN_W(IN_W), .WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_chan (
            .pix(pix[ch]), .wide(cfg_wide), .dith_en(cfg_dither_en),
            .frm_en(cfg_frm_en), .rank(rank), .phase(phase), .q(rnd[ch])
        );

        // Register the channel, forcing zero outside active video.
        always_ff @(posedge clk) begin
            if (!rst_n)     q_reg[ch] <= '0;
            else if (in_de) q_reg[ch] <= rnd[ch];
            else            q_reg[ch] <= '0;
        end
    end

    // Delay the timing flags by the same single stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_reg <= '0;
        else        sync_reg <= '{de: in_de, hs: in_hs, vs: in_vs};
    end

    // Drive the output ports from the pipeline registers.
    always_comb begin
        out_de = sync_reg.de;
        out_hs = sync_reg.hs;
        out_vs = sync_reg.vs;
        out_r  = q_reg[0];
        out_g  = q_reg[1];
        out_b  = q_reg[2];
    end
endmodule

// File: rtl/pdf_dither_frm_chk.sv
// Property checker for pdf_dither_frm, attached by bind below.
module pdf_dither_frm_chk #(
    parameter int IN_W     = 6,
    parameter int WIDE_W   = 4,
    parameter int NARROW_W = 3,
    localparam int DW      = IN_W - WIDE_W,
    localparam int DN      = IN_W - NARROW_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_dither_en,
    input logic              cfg_frm_en,
    input logic              cfg_wide,
    input logic              frame_start,
    input logic              in_de,
    input logic              in_hs,
    input logic              in_vs,
    input logic [IN_W-1:0]   in_r,
    input logic [IN_W-1:0]   in_g,
    input logic [IN_W-1:0]   in_b,
    input logic              out_de,
    input logic              out_hs,
    input logic              out_vs,
    input logic [WIDE_W-1:0] out_r,
    input logic [WIDE_W-1:0] out_g,
    input logic [WIDE_W-1:0] out_b,
    input logic              frame_par
);
    logic            past_ok;
    logic [IN_W-1:0] tr_r, tr_g, tr_b;
    logic [IN_W-1:0] ox_r, ox_g, ox_b;
    logic [IN_W-1:0] max_code;

    // Mark cycles that have a defined previous cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // Truncated reference and zero-extended outputs for comparison.
    always_comb begin
        tr_r     = cfg_wide ? (in_r >> DW) : (in_r >> DN);
        tr_g     = cfg_wide ? (in_g >> DW) : (in_g >> DN);
        tr_b     = cfg_wide ? (in_b >> DW) : (in_b >> DN);
        max_code = cfg_wide ? IN_W'((1 << WIDE_W) - 1) : IN_W'((1 << NARROW_W) - 1);
        ox_r     = IN_W'(out_r);
        ox_g     = IN_W'(out_g);
        ox_b     = IN_W'(out_b);
    end

    a_r1_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (out_de == $past(in_de)) && (out_hs == $past(in_hs)) && (out_vs == $past(in_vs)));

    a_r10_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_de |-> (out_r == '0) && (out_g == '0) && (out_b == '0));

    a_r9_narrow_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(!cfg_wide)) |->
        ((out_r >> NARROW_W) == '0) && ((out_g >> NARROW_W) == '0) && ((out_b >> NARROW_W) == '0));

    a_r3_truncate: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(in_de && !cfg_dither_en && !cfg_frm_en)) |->
        (ox_r == $past(tr_r)) && (ox_g == $past(tr_g)) && (ox_b == $past(tr_b)));

    a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(in_de && (in_r == '1))) |-> (ox_r == $past(max_code)));

    a_r11_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(in_de)) |->
        ((ox_r - $past(tr_r)) <= 1) && ((ox_g - $past(tr_g)) <= 1) && ((ox_b - $past(tr_b)) <= 1));

    a_r8_parity_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(frame_start)) |-> (frame_par != $past(frame_par)));

    a_r8_parity_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(!frame_start)) |-> $stable(frame_par));
endmodule

bind pdf_dither_frm pdf_dither_frm_chk #(
    .IN_W(IN_W), .WIDE_W(WIDE_W), .NARROW_W(NARROW_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_dither_en(cfg_dither_en),
    .cfg_frm_en(cfg_frm_en), .cfg_wide(cfg_wide), .frame_start(frame_start),
    .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs),
    .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs),
    .out_r(out_r), .out_g(out_g), .out_b(out_b),
    .frame_par(frame_par)
);

// File: tb/pdf_dither_frm_tb.sv
// Self-checking bench with a behavioural per-clock reference model.
module pdf_dither_frm_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_dither_en = 1'b0, cfg_frm_en = 1'b0, cfg_wide = 1'b1;
    logic       frame_start = 1'b0;
    logic       in_de = 1'b0, in_hs = 1'b0, in_vs = 1'b0;
    logic       in_x_odd = 1'b0, in_y_odd = 1'b0;
    logic [5:0] in_r = '0, in_g = '0, in_b = '0;
    logic       out_de, out_hs, out_vs;
    logic [3:0] out_r, out_g, out_b;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    bit    cmp_on = 1'b0;
    string cur_req = "R2";

    int m_par = 0;
    int e_de, e_hs, e_vs, e_r, e_g, e_b, t_r, t_g, t_b;

    always #5 clk = ~clk;

    pdf_dither_frm u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_dither_en(cfg_dither_en),
        .cfg_frm_en(cfg_frm_en), .cfg_wide(cfg_wide), .frame_start(frame_start),
        .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs),
        .in_x_odd(in_x_odd), .in_y_odd(in_y_odd),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs),
        .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    // Reference channel model written from R3-R7.
    function automatic int ref_ch(int v, bit wide, bit den, bit fen, bit xo, bit yo, int par);
        int d, up, low, rank, ph, t, mx;
        d   = wide ? 2 : 3;
        up  = v / (1 << d);
        low = v % (1 << d);
        if (!yo && !xo) rank = 0;
        else if (!yo && xo) rank = 2;
        else if (yo && !xo) rank = 3;
        else rank = 1;
        ph = (par + xo + yo) % 2;
        t  = 0;
        if (den) t = rank * (1 << (d - 1));
        if (fen) t = den ? t + ph : ph * (1 << d);
        if (2 * low + t >= (1 << (d + 1))) up = up + 1;
        mx = (1 << (6 - d)) - 1;
        if (up > mx) up = mx;
        return up;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Predict outputs at each edge from the inputs seen there.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_par = 0;
            e_de = 0; e_hs = 0; e_vs = 0; e_r = 0; e_g = 0; e_b = 0;
            t_r = 0; t_g = 0; t_b = 0;
        end else begin
            e_de = in_de; e_hs = in_hs; e_vs = in_vs;
            t_r = cfg_wide ? in_r / 4 : in_r / 8;
            t_g = cfg_wide ? in_g / 4 : in_g / 8;
            t_b = cfg_wide ? in_b / 4 : in_b / 8;
            if (in_de) begin
                e_r = ref_ch(in_r, cfg_wide, cfg_dither_en, cfg_frm_en, in_x_odd, in_y_odd, m_par);
                e_g = ref_ch(in_g, cfg_wide, cfg_dither_en, cfg_frm_en, in_x_odd, in_y_odd, m_par);
                e_b = ref_ch(in_b, cfg_wide, cfg_dither_en, cfg_frm_en, in_x_odd, in_y_odd, m_par);
            end else begin
                e_r = 0; e_g = 0; e_b = 0;
                t_r = 0; t_g = 0; t_b = 0;
            end
            if (frame_start) m_par = 1 - m_par;
        end
    end

    // Compare every cycle, half a period after the edge.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check("R1 de", out_de, e_de);
            check("R1 hs", out_hs, e_hs);
            check("R1 vs", out_vs, e_vs);
            check({cur_req, " red"},   out_r, e_r);
            check({cur_req, " green"}, out_g, e_g);
            check({cur_req, " blue"},  out_b, e_b);
            checks++;
            if (out_r - t_r > 1 || out_r < t_r) begin
                errors++;
                $display("FAIL R11: actual %0d expected %0d or %0d", out_r, t_r, t_r + 1);
            end
        end
    end

    task automatic drive(int r, int g, int b, bit xo, bit yo, bit de, bit fs);
        @(negedge clk);
        in_r = 6'(r); in_g = 6'(g); in_b = 6'(b);
        in_x_odd = xo; in_y_odd = yo; in_de = de; frame_start = fs;
        in_hs = 1'($urandom_range(0, 1)); in_vs = 1'($urandom_range(0, 1));
    endtask

    task automatic sweep(bit wide, bit den, bit fen, string req);
        cfg_wide = wide; cfg_dither_en = den; cfg_frm_en = fen; cur_req = req;
        for (int v = 0; v < 64; v++) begin
            for (int p = 0; p < 4; p++) begin
                drive(v, 63 - v, (v * 7) % 64, p[0], p[1], 1'b1, ($urandom_range(0, 9) == 0));
            end
        end
        drive(0, 0, 0, 0, 0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R2: outputs held at zero during reset
        check("R2 de", out_de, 0);
        check("R2 red", out_r, 0);
        check("R2 blue", out_b, 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // R5 directed: half-code input, phase follows frame parity
        cfg_wide = 1'b1; cfg_frm_en = 1'b1; cur_req = "R5";
        drive(2, 2, 2, 0, 0, 1'b1, 1'b0);
        @(negedge clk); check("R5 parity0", out_r, 0);
        in_de = 1'b0; frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0; in_de = 1'b1;
        @(negedge clk); check("R5 parity1", out_r, 1);
        cfg_frm_en = 1'b0;

        // R4 directed: rank 2 position rounds 2 up, rank 0 does not
        cfg_dither_en = 1'b1; cur_req = "R4";
        drive(2, 2, 2, 1, 0, 1'b1, 1'b0);
        @(negedge clk); check("R4 rank2", out_r, 1);
        drive(2, 2, 2, 0, 0, 1'b1, 1'b0);
        @(negedge clk); check("R4 rank0", out_r, 0);

        for (int w = 0; w < 2; w++) begin
            sweep(w[0], 1'b0, 1'b0, "R3");
            sweep(w[0], 1'b1, 1'b0, "R4");
            sweep(w[0], 1'b0, 1'b1, "R5");
            sweep(w[0], 1'b1, 1'b1, "R6");
        end

        // R7: full-scale input saturates in both widths and all modes
        cur_req = "R7";
        for (int k = 0; k < 8; k++) begin
            cfg_wide = k[0]; cfg_dither_en = k[1]; cfg_frm_en = k[2];
            for (int p = 0; p < 4; p++) drive(63, 63, 63, p[0], p[1], 1'b1, 1'b1);
            @(negedge clk);
            check("R7 sat", out_r, k[0] ? 15 : 7);
        end

        // R8: frame pulses on active pixels, half-code inputs
        cur_req = "R8"; cfg_wide = 1'b0; cfg_dither_en = 1'b0; cfg_frm_en = 1'b1;
        for (int i = 0; i < 200; i++)
            drive(4 + 8 * (i % 8), 12, 20, i[0], i[1], 1'b1, i[2] ^ i[4]);

        // R9: narrow mode, random pixels, top bit stays clear
        cur_req = "R9"; cfg_dither_en = 1'b1;
        for (int i = 0; i < 200; i++) begin
            drive($urandom_range(0, 63), $urandom_range(0, 63), $urandom_range(0, 63),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'b1, 1'b0);
            @(negedge clk);
            check("R9 msb", int'(out_g[3]), 0);
        end

        // R10: random blanking with nonzero colour inputs
        cur_req = "R10"; cfg_wide = 1'b1;
        for (int i = 0; i < 300; i++)
            drive($urandom_range(1, 63), $urandom_range(1, 63), $urandom_range(1, 63),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), ($urandom_range(0, 15) == 0));
        drive(0, 0, 0, 0, 0, 1'b0, 1'b0);
        @(negedge clk);
        check("R10 blank", out_r + out_g + out_b, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule